// File: doc/BRIEF.md
# Programmable Sum-of-Products Logic Array

This block is a small field-configurable combinational logic array. Sixteen matrix variables reach a programmable AND plane, each as a true line and a complement line. A configuration cell at every crossing of a product line and an input line decides whether that line joins the product. The product lines are split into eight fixed groups of eight. In each group, the first line drives the three-state enable of the group's output, and the other seven are ORed into the output. The output is driven active-LOW.

Ten matrix variables come from dedicated inputs. The other six are fed back from the first six output pins. Each pad is modelled with separate drive, enable and sense ports. A pad's feedback value is the value seen on the pad: the driven value when its enable is high, and the external value on `io_in` when it is not. This value is captured in a register once per clock, so every feedback path lasts exactly one cycle and the array has no combinational loop.

The configuration is shifted in serially, one bit per clock. A commit pulse then marks the configuration as valid. All enables stay low from reset until a commit, and they drop again as soon as a new load starts.

Top module: `pal_sop_array`

## Requirements
- R1: After reset, every configuration cell is connected and no commit has been taken. Every `out_en` bit is 0. With all cells connected, every `out_n` bit is 1.
- R2: In a cycle where `cfg_shift_en` is 1, the cell chain moves one place toward index 0, and `cfg_bit` enters at the highest index. After a full load, the bit shifted first sits at cell 0. The cell index of product line L and input line c is L*32 + c, where L = group*8 + position in group. Input line c = 2j is matrix variable j true, and c = 2j+1 is variable j complement. The chain holds its value in cycles without a shift.
- R3: A cell holding 1 includes its input line in the product. A cell holding 0 contributes logic HIGH, so it does not affect the product.
- R4: A product line with every cell at 1 evaluates to 0. The erased configuration therefore gives `out_n` all 1 and `out_en` all 0 for any input values.
- R5: `out_n[g]` is 0 when any of product lines g*8+1 through g*8+7 is 1. Otherwise it is 1.
- R6: `out_en[g]` is the value of product line g*8, taken only after a commit.
- R7: `cfg_commit` alone marks the configuration valid from the next cycle. Any cycle with `cfg_shift_en` high clears that mark from the next cycle, even if `cfg_commit` is also high. While the mark is clear, `out_en` is all 0.
- R8: Matrix variables 0 to 9 are `ded_in[9:0]`. Variables 10 to 15 are feedback from pads 0 to 5. Each feedback value is a register loaded every cycle with `out_n[k]` when `out_en[k]` is 1, and with `io_in[k]` when it is 0. The register resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_shift_en | input | 1 | Shift one configuration bit this cycle |
| cfg_bit | input | 1 | Serial configuration data |
| cfg_commit | input | 1 | Mark the loaded configuration valid |
| ded_in | input | 10 | Dedicated matrix inputs |
| io_in | input | 6 | Value sensed on bidirectional pads 0 to 5 |
| out_n | output | 8 | Active-LOW sum-of-products value driven to each pad |
| out_en | output | 8 | Three-state enable of each pad driver |

## Verification
The hardest case is a function whose inputs include its own or another group's feedback. There the expected output depends on the pad values of the previous cycle, which in turn came from the enables and the external pad values. The bench keeps its own one-cycle feedback model, updated at each edge from its predicted pad values. A directed configuration chains group 0's pad into group 1. Sparse random configurations, with about one cell in twelve connected, leave many product terms live. A final single shift, with commit also held high, moves the whole chain by one place and checks the ordering of the cells.

// File: rtl/pal_pkg.sv
package pal_pkg;
    localparam int unsigned DEF_DED_N  = 10;
    localparam int unsigned DEF_IO_N   = 6;
    localparam int unsigned DEF_GRP_N  = 8;
    localparam int unsigned DEF_LINE_N = 8;
endpackage

// File: rtl/pal_cfg_store.sv
module pal_cfg_store #(
    parameter int unsigned CELL_N = 2048
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              shift_bit,
    input  logic              commit,
    output logic [CELL_N-1:0] cells,
    output logic              loaded
);
    typedef struct packed {
        logic [CELL_N-1:0] cells;
        logic              loaded;
    } cfg_st_t;

    cfg_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (shift_en) begin
            st_d.cells  = {shift_bit, st_q.cells[CELL_N-1:1]};
            st_d.loaded = 1'b0;
        end else if (commit) begin
            st_d.loaded = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cells  <= '1;
            st_q.loaded <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cells  = st_q.cells;
    assign loaded = st_q.loaded;

    assert_shift_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (cells[CELL_N-1] == $past(shift_bit)));
    assert_hold_chain_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(cells));
    assert_shift_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> !loaded);
    assert_commit_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !shift_en) |=> loaded);
endmodule

// File: rtl/pal_and_plane.sv
module pal_and_plane #(
    parameter int unsigned MTX_N = 16,
    parameter int unsigned PT_N  = 64,
    localparam int unsigned COL_N = 2 * MTX_N
) (
    input  logic [MTX_N-1:0]      mtx,
    input  logic [PT_N*COL_N-1:0] cells,
    output logic [PT_N-1:0]       prod
);
    logic [COL_N-1:0] in_lines;

    for (genvar j = 0; j < MTX_N; j++) begin : g_lines
        assign in_lines[2*j]   = mtx[j];
        assign in_lines[2*j+1] = ~mtx[j];
    end

    for (genvar p = 0; p < PT_N; p++) begin : g_pt
        logic [COL_N-1:0] sel;
        assign sel     = cells[p*COL_N +: COL_N];
        assign prod[p] = &(in_lines | ~sel);

        always_comb begin
            if (&sel) begin
                assert_full_line_zero_R4: assert (!prod[p])
                    else $error("fully connected product line is not 0");
            end
        end
    end
endmodule

// File: rtl/pal_or_group.sv
module pal_or_group #(
    parameter int unsigned GRP_N  = 8,
    parameter int unsigned LINE_N = 8,
    localparam int unsigned SUM_N = LINE_N - 1
) (
    input  logic [GRP_N*LINE_N-1:0] prod,
    input  logic                    loaded,
    output logic [GRP_N-1:0]        out_n,
    output logic [GRP_N-1:0]        out_en
);
    for (genvar g = 0; g < GRP_N; g++) begin : g_grp
        logic [SUM_N-1:0] terms;
        assign terms     = prod[g*LINE_N+1 +: SUM_N];
        assign out_en[g] = loaded & prod[g*LINE_N];
        assign out_n[g]  = ~(|terms);
    end
endmodule

// File: rtl/pal_sop_array.sv
module pal_sop_array
    import pal_pkg::*;
#(
    parameter int unsigned DED_N  = DEF_DED_N,
    parameter int unsigned IO_N   = DEF_IO_N,
    parameter int unsigned GRP_N  = DEF_GRP_N,
    parameter int unsigned LINE_N = DEF_LINE_N,
    localparam int unsigned MTX_N  = DED_N + IO_N,
    localparam int unsigned COL_N  = 2 * MTX_N,
    localparam int unsigned PT_N   = GRP_N * LINE_N,
    localparam int unsigned CELL_N = PT_N * COL_N
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_shift_en,
    input  logic             cfg_bit,
    input  logic             cfg_commit,
    input  logic [DED_N-1:0] ded_in,
    input  logic [IO_N-1:0]  io_in,
    output logic [GRP_N-1:0] out_n,
    output logic [GRP_N-1:0] out_en
);
    typedef struct packed {
        logic [IO_N-1:0] fb;
    } fb_st_t;

    fb_st_t fb_d, fb_q;

    logic [CELL_N-1:0] cells;
    logic              cfg_loaded;
    logic [PT_N-1:0]   prod;
    logic [MTX_N-1:0]  mtx;
    logic [IO_N-1:0]   pad_val;

    pal_cfg_store #(.CELL_N(CELL_N)) cfg_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (cfg_shift_en),
        .shift_bit (cfg_bit),
        .commit    (cfg_commit),
        .cells     (cells),
        .loaded    (cfg_loaded)
    );

    assign mtx = {fb_q.fb, ded_in};

    pal_and_plane #(.MTX_N(MTX_N), .PT_N(PT_N)) and_i (
        .mtx   (mtx),
        .cells (cells),
        .prod  (prod)
    );

    pal_or_group #(.GRP_N(GRP_N), .LINE_N(LINE_N)) or_i (
        .prod   (prod),
        .loaded (cfg_loaded),
        .out_n  (out_n),
        .out_en (out_en)
    );

    for (genvar k = 0; k < IO_N; k++) begin : g_pad
        assign pad_val[k] = out_en[k] ? out_n[k] : io_in[k];

        assert_fb_from_pad_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !out_en[k] |=> (fb_q.fb[k] == $past(io_in[k])));
    end

    always_comb begin
        fb_d    = fb_q;
        fb_d.fb = pad_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fb_q <= '0;
        end else begin
            fb_q <= fb_d;
        end
    end

    assert_hiz_until_commit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_loaded |-> (out_en == '0));
endmodule

// File: tb/pal_sop_array_tb_top.sv
`timescale 1ns/1ps
module pal_sop_array_tb_top;
    import pal_pkg::*;
    localparam int DW = DEF_DED_N;
    localparam int IW = DEF_IO_N;
    localparam int GN = DEF_GRP_N;
    localparam int LN = DEF_LINE_N;
    localparam int MN = DW + IW;
    localparam int CN = 2 * MN;
    localparam int PN = GN * LN;
    localparam int NC = PN * CN;

    // {ded_in, io_in, expected out_n[0], expected out_en[0]} for the directed setup
    localparam logic [17:0] TBL [8] = '{
        {10'h000, 6'h00, 1'b1, 1'b0},
        {10'h003, 6'h00, 1'b0, 1'b0},
        {10'h203, 6'h01, 1'b0, 1'b1},
        {10'h201, 6'h3F, 1'b1, 1'b1},
        {10'h202, 6'h00, 1'b1, 1'b1},
        {10'h003, 6'h01, 1'b0, 1'b0},
        {10'h3FF, 6'h2A, 1'b0, 1'b1},
        {10'h200, 6'h15, 1'b1, 1'b1}
    };

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          cfg_shift_en = 1'b0;
    logic          cfg_bit = 1'b0;
    logic          cfg_commit = 1'b0;
    logic [DW-1:0] ded_in = '0;
    logic [IW-1:0] io_in = '0;
    logic [GN-1:0] out_n;
    logic [GN-1:0] out_en;

    int errs = 0;
    int checks = 0;
    bit done = 1'b0;

    logic          cfg_m [NC];
    logic          loaded_m = 1'b0;
    logic [IW-1:0] fb_m = '0;

    pal_sop_array dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_shift_en (cfg_shift_en),
        .cfg_bit      (cfg_bit),
        .cfg_commit   (cfg_commit),
        .ded_in       (ded_in),
        .io_in        (io_in),
        .out_n        (out_n),
        .out_en       (out_en)
    );

    function automatic int cidx(int line, int col);
        return line * CN + col;
    endfunction

    function automatic logic prod_m(int line, logic [MN-1:0] m);
        for (int j = 0; j < MN; j++) begin
            if (cfg_m[cidx(line, 2*j)] && !m[j]) return 1'b0;
            if (cfg_m[cidx(line, 2*j+1)] && m[j]) return 1'b0;
        end
        return 1'b1;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic [DW-1:0] d, input logic [IW-1:0] io,
                        input logic use_tbl, input logic on0, input logic en0);
        logic [MN-1:0] m;
        logic [GN-1:0] en_e;
        logic [GN-1:0] on_e;
        logic [IW-1:0] pads;
        logic          sum;
        @(negedge clk);
        ded_in = d;
        io_in  = io;
        #1;
        m = {fb_m, d};
        for (int g = 0; g < GN; g++) begin
            en_e[g] = loaded_m & prod_m(g*LN, m);
            sum = 1'b0;
            for (int p = 1; p < LN; p++) sum = sum | prod_m(g*LN + p, m);
            on_e[g] = ~sum;
        end
        chk("R2 R3 R5 R8 out_n vs model", 32'(out_n), 32'(on_e));
        chk("R6 R7 out_en vs model", 32'(out_en), 32'(en_e));
        if (use_tbl) chk("R5 R6 table group0 {out_n0,out_en0}",
                         32'({out_n[0], out_en[0]}), 32'({on0, en0}));
        for (int k = 0; k < IW; k++) pads[k] = en_e[k] ? on_e[k] : io[k];
        @(posedge clk);
        fb_m = pads;
    endtask

    task automatic do_commit();
        @(negedge clk);
        cfg_shift_en = 1'b0;
        cfg_commit   = 1'b1;
        @(posedge clk);
        #1;
        cfg_commit = 1'b0;
        loaded_m   = 1'b1;
        fb_m       = io_in;
    endtask

    task automatic load_cfg();
        loaded_m = 1'b0;
        for (int i = 0; i < NC; i++) begin
            @(negedge clk);
            cfg_shift_en = 1'b1;
            cfg_bit      = cfg_m[i];
            if (i == NC / 2) begin
                #1;
                chk("R7 enables low while shifting", 32'(out_en), 32'h0);
            end
        end
        do_commit();
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errs, checks);
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            checks++;
            errs++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NC; i++) cfg_m[i] = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 reset out_en", 32'(out_en), 32'h0);
        chk("R1 reset out_n", 32'(out_n), 32'hFF);
        rst_n = 1'b1;
        step(10'h3FF, 6'h3F, 1'b0, 1'b0, 1'b0);
        step(10'h155, 6'h0A, 1'b0, 1'b0, 1'b0);
        chk("R1 no commit yet out_en", 32'(out_en), 32'h0);

        // erased array committed: every line fully connected
        do_commit();
        step(10'h000, 6'h00, 1'b0, 1'b0, 1'b0);
        step(10'h2AA, 6'h15, 1'b0, 1'b0, 1'b0);
        chk("R4 erased out_n", 32'(out_n), 32'hFF);
        chk("R4 erased out_en", 32'(out_en), 32'h0);

        // directed configuration
        for (int i = 0; i < NC; i++) cfg_m[i] = 1'b1;
        for (int c = 0; c < CN; c++) begin
            cfg_m[cidx(0, c)]  = 1'b0;
            cfg_m[cidx(1, c)]  = 1'b0;
            cfg_m[cidx(8, c)]  = 1'b0;
            cfg_m[cidx(9, c)]  = 1'b0;
            cfg_m[cidx(16, c)] = 1'b0;
            cfg_m[cidx(17, c)] = 1'b0;
        end
        cfg_m[cidx(0, 18)]  = 1'b1;
        cfg_m[cidx(1, 0)]   = 1'b1;
        cfg_m[cidx(1, 2)]   = 1'b1;
        cfg_m[cidx(9, 20)]  = 1'b1;
        cfg_m[cidx(17, 1)]  = 1'b1;
        load_cfg();
        for (int t = 0; t < 8; t++)
            step(TBL[t][17:8], TBL[t][7:2], 1'b1, TBL[t][1], TBL[t][0]);

        // sparse random configurations
        for (int r = 0; r < 3; r++) begin
            for (int i = 0; i < NC; i++) cfg_m[i] = ($urandom_range(0, 11) == 0);
            load_cfg();
            for (int s = 0; s < 40; s++)
                step(DW'($urandom()), IW'($urandom()), 1'b0, 1'b0, 1'b0);
        end

        // one shift together with commit: shift wins, chain moves by one place
        @(negedge clk);
        cfg_shift_en = 1'b1;
        cfg_commit   = 1'b1;
        cfg_bit      = 1'b1;
        for (int i = 0; i < NC - 1; i++) cfg_m[i] = cfg_m[i+1];
        cfg_m[NC-1] = 1'b1;
        @(negedge clk);
        cfg_shift_en = 1'b0;
        cfg_commit   = 1'b0;
        #1;
        chk("R7 shift beats commit out_en", 32'(out_en), 32'h0);
        do_commit();
        for (int s = 0; s < 20; s++)
            step(DW'($urandom()), IW'($urandom()), 1'b0, 1'b0, 1'b0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule